// File: doc/BRIEF.md
# Double-Buffered Receive Packet FIFO

This block holds packets that arrive for one receive endpoint of a USB device until the processor has read them out. The USB engine hands over a byte stream in which each beat carries a data byte, an end-of-packet marker, or an error indication. Once a packet closes cleanly it is queued in one of two packet buffers. The processor sees a ready flag and the packet's byte count. It pulls the bytes one at a time through a read strobe and then releases the buffer by pulsing a clear input.

A configuration bit picks one of two modes. In single mode only one packet is held at a time. In double mode two complete packets can wait, and the second becomes current as soon as the first is released. A second configuration bit marks the endpoint as isochronous. For such an endpoint, a packet that finds no buffer is thrown away. For bulk and interrupt endpoints the block holds off the stream and raises a NAK request, so that the host retries.

The input stream follows valid/ready rules. A beat is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` drops only between packets, and only when a bulk or interrupt endpoint has no free buffer. While it is low the source must hold its beat. The configuration inputs are expected to change only while reset is asserted.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset, `pkt_rdy`, `irq`, `pkt_cnt`, `rd_data` and `rx_nak` are 0 and `in_ready` is 1.
- R2: A beat is taken when `in_valid` and `in_ready` are both high. A beat with `in_err`=1 is an error beat, whatever `in_eop` is. A beat with `in_eop`=1 and `in_err`=0 is an end marker and carries no byte. Any other beat carries `in_data` as one byte.
- R3: In the cycle after an end marker is taken, a packet that becomes current shows `pkt_rdy`=1 and `pkt_cnt` equal to its number of data bytes. Zero-length packets are allowed.
- R4: While `pkt_rdy`=1, `rd_data` shows the byte at the read position, starting from the first byte. Each cycle with `rd_strobe`=1 moves the read position to the next byte, so the bytes come out in arrival order.
- R5: Once every byte has been read, `rd_data` is 0 and further strobes do not move the position. `rd_data` is also 0 while `pkt_rdy`=0.
- R6: A `clr_rdy` pulse while `pkt_rdy`=1 frees the current buffer and resets the read position. A pulse while `pkt_rdy`=0 has no effect.
- R7: `irq` is a one-cycle pulse in the first cycle that a new packet is current. It occurs only if `irq_en` was 1 on the edge before.
- R8: In double mode (`cfg_dbl`=1), two packets are held. A clear while a second packet is waiting keeps `pkt_rdy` high and shows the second packet's count. It also pulses `irq` again.
- R9: In single mode (`cfg_dbl`=0), at most one complete packet is held at any time.
- R10: With `cfg_iso`=0, when no buffer is free between packets, `rx_nak`=1 and `in_ready`=0. No packet is lost, and input resumes once a buffer is freed.
- R11: With `cfg_iso`=1, `rx_nak` stays 0. A packet that starts when no buffer is free is taken and discarded as a whole.
- R12: An error beat drops the packet in progress, and its buffer stays free for the next packet.
- R13: A packet with more than `MAX_PKT` data bytes is discarded as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dbl | input | 1 | 1 selects two packet buffers |
| cfg_iso | input | 1 | 1 selects isochronous drop behaviour |
| irq_en | input | 1 | Interrupt enable |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted when high |
| in_data | input | DATA_W | Stream data byte |
| in_eop | input | 1 | Beat is an end-of-packet marker |
| in_err | input | 1 | Beat flags the packet as bad |
| rx_nak | output | 1 | Request to NAK the host (no free buffer) |
| rd_strobe | input | 1 | Processor read of the data register |
| rd_data | output | DATA_W | Byte at the read position |
| clr_rdy | input | 1 | Processor releases the current packet |
| pkt_rdy | output | 1 | A complete packet is current |
| pkt_cnt | output | $clog2(MAX_PKT+1) | Byte count of the current packet |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with `MAX_PKT`=4 and 8-bit data. With that size every packet length from zero to the limit, plus one byte over it, can be swept in each of the four combinations of buffering and endpoint mode. The small buffer count also makes the full-queue cases easy to reach: NAK stall and later resumption, isochronous discard, and interrupt re-assertion on release. Expected bytes are computed as a function of a packet seed and the byte index.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int NBUF = 2;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_FILL,
    FS_DROP
  } fill_state_e;
endpackage

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
  import rxbuf_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dbl,
  input  logic              cfg_iso,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eop,
  input  logic              in_err,
  input  logic [NBUF-1:0]   full,
  output logic              in_ready,
  output logic              rx_nak,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic              commit_buf,
  output logic [CW-1:0]     commit_len
);
  fill_state_e state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_sel, wr_sel_n;
  logic          buf_free, take, is_err, is_eop, is_dat;

  // Free check only matters at a packet start
  assign buf_free = cfg_dbl ? !full[wr_sel] : (full == '0);
  assign rx_nak   = (state == FS_IDLE) && !cfg_iso && !buf_free;
  assign in_ready = !rx_nak;
  assign take     = in_valid && in_ready;
  assign is_err   = in_err;
  assign is_eop   = in_eop && !in_err;
  assign is_dat   = !in_eop && !in_err;

  assign wr_buf     = wr_sel;
  assign wr_addr    = cnt[AW-1:0];
  assign wr_data    = in_data;
  assign commit_buf = wr_sel;
  assign commit_len = cnt;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    wr_sel_n = wr_sel;
    wr_en    = 1'b0;
    commit   = 1'b0;
    if (take) begin
      unique case (state)
        FS_IDLE: begin
          if (is_dat) begin
            if (buf_free) begin
              wr_en   = 1'b1;
              cnt_n   = CW'(1);
              state_n = FS_FILL;
            end else begin
              state_n = FS_DROP;
            end
          end else if (is_eop && buf_free) begin
            commit   = 1'b1;
            wr_sel_n = ~wr_sel;
          end
        end
        FS_FILL: begin
          if (is_err) begin
            state_n = FS_IDLE;
            cnt_n   = '0;
          end else if (is_eop) begin
            commit   = 1'b1;
            wr_sel_n = ~wr_sel;
            state_n  = FS_IDLE;
            cnt_n    = '0;
          end else if (cnt == CW'(MAX_PKT)) begin
            state_n = FS_DROP;
            cnt_n   = '0;
          end else begin
            wr_en = 1'b1;
            cnt_n = cnt + CW'(1);
          end
        end
        FS_DROP: begin
          if (!is_dat) state_n = FS_IDLE;
        end
        default: state_n = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      cnt    <= '0;
      wr_sel <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      wr_sel <= wr_sel_n;
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              commit_buf,
  input  logic [CW-1:0]     commit_len,
  input  logic              release_en,
  input  logic              release_buf,
  input  logic              rd_buf,
  input  logic [AW-1:0]     rd_addr,
  output logic [NBUF-1:0]   full,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CW-1:0]     rd_len
);
  logic [DATA_W-1:0] byte_b [NBUF];
  logic [CW-1:0]     len_q  [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [DATA_W-1:0] mem [MAX_PKT];

    always_ff @(posedge clk) begin
      if (wr_en && wr_buf == 1'(b)) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full[b]  <= 1'b0;
        len_q[b] <= '0;
      end else if (commit && commit_buf == 1'(b)) begin
        full[b]  <= 1'b1;
        len_q[b] <= commit_len;
      end else if (release_en && release_buf == 1'(b)) begin
        full[b]  <= 1'b0;
      end
    end

    assign byte_b[b] = mem[rd_addr];
  end

  assign rd_byte = byte_b[rd_buf];
  assign rd_len  = len_q[rd_buf];
endmodule

// File: rtl/rxbuf_drain.sv
module rxbuf_drain
  import rxbuf_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic [NBUF-1:0]   full,
  input  logic              commit,
  input  logic              commit_buf,
  input  logic [CW-1:0]     rd_len,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              rd_strobe,
  input  logic              clr_rdy,
  output logic              rd_sel,
  output logic [AW-1:0]     rd_addr,
  output logic              release_en,
  output logic              pkt_rdy,
  output logic [CW-1:0]     pkt_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CW-1:0] pos;
  logic          more, rd_sel_n, next_rdy, new_pkt;

  assign pkt_rdy    = full[rd_sel];
  assign release_en = clr_rdy && pkt_rdy;
  assign more       = pkt_rdy && (pos < rd_len);
  assign rd_data    = more ? rd_byte : '0;
  assign pkt_cnt    = pkt_rdy ? rd_len : '0;
  assign rd_addr    = pos[AW-1:0];

  // Which buffer is current after this edge, and is it a fresh packet
  assign rd_sel_n = release_en ? ~rd_sel : rd_sel;
  assign next_rdy = full[rd_sel_n] || (commit && commit_buf == rd_sel_n);
  assign new_pkt  = next_rdy && (!pkt_rdy || release_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      rd_sel <= 1'b0;
      irq    <= 1'b0;
    end else begin
      rd_sel <= rd_sel_n;
      irq    <= irq_en && new_pkt;
      if (release_en)             pos <= '0;
      else if (rd_strobe && more) pos <= pos + CW'(1);
    end
  end
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxbuf_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dbl,
  input  logic              cfg_iso,
  input  logic              irq_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eop,
  input  logic              in_err,
  output logic              rx_nak,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clr_rdy,
  output logic              pkt_rdy,
  output logic [CW-1:0]     pkt_cnt,
  output logic              irq
);
  logic [NBUF-1:0]   full;
  logic              wr_en, wr_buf, commit, commit_buf, release_en, rd_sel;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_byte;
  logic [CW-1:0]     commit_len, rd_len;

  rxbuf_fill #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_iso(cfg_iso),
    .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop), .in_err(in_err),
    .full(full), .in_ready(in_ready), .rx_nak(rx_nak),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_buf(commit_buf), .commit_len(commit_len)
  );

  rxbuf_store #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_buf(commit_buf), .commit_len(commit_len),
    .release_en(release_en), .release_buf(rd_sel),
    .rd_buf(rd_sel), .rd_addr(rd_addr),
    .full(full), .rd_byte(rd_byte), .rd_len(rd_len)
  );

  rxbuf_drain #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .full(full),
    .commit(commit), .commit_buf(commit_buf),
    .rd_len(rd_len), .rd_byte(rd_byte), .rd_strobe(rd_strobe), .clr_rdy(clr_rdy),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .release_en(release_en),
    .pkt_rdy(pkt_rdy), .pkt_cnt(pkt_cnt), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int MAX_PKT = 64,
  parameter int DATA_W  = 8,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_dbl,
  input logic              cfg_iso,
  input logic              irq_en,
  input logic              in_ready,
  input logic              rx_nak,
  input logic              pkt_rdy,
  input logic [CW-1:0]     pkt_cnt,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [1:0]        full
);
  assert_nak_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nak |-> !in_ready);

  assert_iso_no_nak_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_iso |-> !rx_nak);

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> (pkt_cnt <= CW'(MAX_PKT)));

  assert_idle_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_rdy |-> (rd_data == '0));

  assert_irq_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pkt_rdy);

  assert_irq_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pkt_rdy) && $past(irq_en)) |-> irq);

  assert_single_holds_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dbl |-> ($countones(full) <= 1));
endmodule

bind rx_pkt_buffer rxbuf_checker #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_iso(cfg_iso), .irq_en(irq_en),
  .in_ready(in_ready), .rx_nak(rx_nak), .pkt_rdy(pkt_rdy), .pkt_cnt(pkt_cnt),
  .rd_data(rd_data), .irq(irq), .full(full)
);

// File: tb/tb_rx_pkt_buffer.sv
`timescale 1ns/1ps
module tb_rx_pkt_buffer;
  localparam int MAXP = 4;
  localparam int CW   = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dbl = 1'b0, cfg_iso = 1'b0, irq_en = 1'b0;
  logic in_valid = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic rd_strobe = 1'b0, clr_rdy = 1'b0;
  logic in_ready, rx_nak, pkt_rdy, irq;
  logic [7:0] rd_data;
  logic [CW-1:0] pkt_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  rx_pkt_buffer #(.MAX_PKT(MAXP), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_iso(cfg_iso), .irq_en(irq_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .in_err(in_err), .rx_nak(rx_nak), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .clr_rdy(clr_rdy), .pkt_rdy(pkt_rdy), .pkt_cnt(pkt_cnt), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int byte_of(input int seed, input int i);
    return (seed * 16 + i + 1) & 255;
  endfunction

  task automatic beat(input int d, input bit e, input bit er);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'(d); in_eop = e; in_err = er;
    for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0; in_err = 1'b0;
  endtask

  task automatic send(input int len, input int seed);
    for (int i = 0; i < len; i++) beat(byte_of(seed, i), 1'b0, 1'b0);
    beat(0, 1'b1, 1'b0);
    idle_in();
  endtask

  // Error beat with the end marker also set: the error must win (R2, R12)
  task automatic send_bad(input int len, input int seed);
    for (int i = 0; i < len; i++) beat(byte_of(seed, i), 1'b0, 1'b0);
    beat(0, 1'b1, 1'b1);
    idle_in();
  endtask

  task automatic drain(input string req, input int len, input int seed);
    chk({req, " ready"}, pkt_rdy, 1);
    chk({req, " count"}, pkt_cnt, len);
    for (int i = 0; i <= len; i++) begin
      chk({req, " byte (R4)"}, rd_data, (i < len) ? byte_of(seed, i) : 0);
      rd_strobe = 1'b1;
      @(negedge clk);
    end
    rd_strobe = 1'b0;
    chk("R5 past end", rd_data, 0);
    chk("R5 count kept", pkt_cnt, len);
  endtask

  task automatic release_pkt();
    clr_rdy = 1'b1;
    @(negedge clk);
    clr_rdy = 1'b0;
  endtask

  task automatic do_reset(input bit dbl, input bit iso, input bit ien);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_dbl = dbl; cfg_iso = iso; irq_en = ien;
    in_valid = 1'b0; in_eop = 1'b0; in_err = 1'b0; rd_strobe = 1'b0; clr_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pkt_rdy", pkt_rdy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 count", pkt_cnt, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 rx_nak", rx_nak, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit dbl, iso;
      dbl = cfg[1];
      iso = cfg[0];
      do_reset(dbl, iso, 1'b1);

      // R3/R4/R5/R7: every length from zero to the limit
      for (int len = 0; len <= MAXP; len++) begin
        send(len, len + cfg * 5);
        chk("R7 irq on new packet", irq, 1);
        drain("R3", len, len + cfg * 5);
        chk("R7 irq single pulse", irq, 0);
        release_pkt();
        chk("R6 released", pkt_rdy, 0);
      end

      // R13: one byte too many
      send(MAXP + 1, 9);
      chk("R13 oversize dropped", pkt_rdy, 0);
      chk("R13 input open", in_ready, 1);

      // R12/R2: error beat drops, buffer stays usable
      send_bad(2, 3);
      chk("R12 bad packet dropped", pkt_rdy, 0);
      chk("R2 error wins over marker", irq, 0);
      send(1, 4);
      drain("R12 next packet", 1, 4);
      release_pkt();

      // R6: clear with nothing ready has no effect
      release_pkt();
      send(2, 6);
      chk("R6 ignored clear", pkt_rdy, 1);
      chk("R6 ignored clear count", pkt_cnt, 2);
      drain("R6", 2, 6);
      release_pkt();

      // Two packets back to back
      send(3, 7);
      chk("R7 irq first", irq, 1);
      if (dbl) begin
        send(2, 8);
        chk("R8 second not current", irq, 0);
        drain("R8 first", 3, 7);
        release_pkt();
        chk("R8 re-assert", pkt_rdy, 1);
        chk("R8 new irq", irq, 1);
        drain("R8 second", 2, 8);
        release_pkt();
        chk("R8 empty", pkt_rdy, 0);
        send(1, 10);
        send(2, 11);
        if (!iso) begin
          @(negedge clk);
          in_valid = 1'b1; in_data = 8'(byte_of(12, 0)); in_eop = 1'b0;
          chk("R10 stall both full", in_ready, 0);
          chk("R10 nak both full", rx_nak, 1);
          repeat (3) @(negedge clk);
          chk("R10 still stalled", in_ready, 0);
          release_pkt();
          chk("R10 resumes", in_ready, 1);
          chk("R10 nak cleared", rx_nak, 0);
          in_valid = 1'b0;
          send(1, 12);
          drain("R10 queued", 2, 11);
          release_pkt();
          drain("R10 held back", 1, 12);
          release_pkt();
        end else begin
          send(1, 12);
          chk("R11 no nak", rx_nak, 0);
          drain("R11 first kept", 1, 10);
          release_pkt();
          drain("R11 second kept", 2, 11);
          release_pkt();
          chk("R11 third discarded", pkt_rdy, 0);
        end
      end else begin
        if (!iso) begin
          @(negedge clk);
          in_valid = 1'b1; in_data = 8'(byte_of(8, 0)); in_eop = 1'b0;
          chk("R9 single stall", in_ready, 0);
          chk("R10 nak single", rx_nak, 1);
          repeat (3) @(negedge clk);
          chk("R10 first kept", pkt_cnt, 3);
          release_pkt();
          chk("R10 resumes", in_ready, 1);
          in_valid = 1'b0;
          send(2, 8);
          chk("R9 irq after wait", irq, 1);
          drain("R9 waited packet", 2, 8);
          release_pkt();
        end else begin
          send(2, 8);
          chk("R11 no nak", rx_nak, 0);
          drain("R11 first kept", 3, 7);
          release_pkt();
          chk("R11 second discarded", pkt_rdy, 0);
        end
      end

      // R7: interrupt disabled
      do_reset(dbl, iso, 1'b0);
      send(2, 13);
      chk("R7 irq masked", irq, 0);
      chk("R7 ready without irq", pkt_rdy, 1);
      release_pkt();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule